// File: doc/BRIEF.md
# Write-Only I2C Control Register Target

This block is a write-only I2C target that keeps a small bank of audio control settings. It oversamples SCL and SDA with the system clock, finds start and stop conditions, and shifts in bytes. It acknowledges its own address by enabling an open-drain pull-down on SDA. One bit of its address comes from a strap pin, so two such targets can share a bus.

No register pointer byte follows the address. Instead, the upper bits of each data byte form a prefix of variable length, and that prefix picks the field the byte loads. A host can send any number of setting bytes in one transfer. Each byte is acknowledged, and each one takes effect only once its acknowledge clock has finished.

The decoded fields drive the analog side of the chip directly:
- a 4-bit output routing mode,
- a 2-bit headphone attenuation select,
- a right-headphone shutdown,
- an input mute,
- three 5-bit volume codes (mono, left and right).

Top module: `ctl_i2c_regs`

## Requirements
- R1: The block acknowledges an address byte equal to 0xF8 when `addr_sel_i` is 0, or 0xFA when it is 1. The address byte is sent MSB first, bit 0 is the read/write flag and must be 0, and bit 1 equals `addr_sel_i`. The acknowledge is `sda_pull_o` = 1 throughout the ninth SCL high phase.
- R2: The block does not acknowledge any other address byte, a read flag of 1 included. After such a byte it drives no acknowledge and updates no field until the next start.
- R3: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A repeated start (a start with no stop before it) restarts address reception.
- R4: Bits are sampled on rising SCL edges, MSB first.
- R5: A data byte of the form 0011_xxxx loads bits 3:0 into `mode_o`.
- R6: A data byte of the form 010x_xxxx loads three fields: bit 4 into `in_mute_o`, bit 2 into `hp_r_off_o`, and bits 1:0 into `hp_atten_o`.
- R7: Three prefixes load bits 4:0 into a volume code. Prefix 100 loads `vol_mono_o`, prefix 110 loads `vol_left_o`, and prefix 111 loads `vol_right_o`.
- R8: A data byte that matches no prefix is acknowledged, and it changes no output.
- R9: Any number of data bytes may follow the address, and each of them is acknowledged.
- R10: While reset is asserted, every field output and `sda_pull_o` are 0. A mode of 0 means full shutdown.
- R11: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` (3) system clocks has no effect.
- R12: A field changes only after the acknowledge clock of its byte has completed. A byte that a stop cuts short changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 20x the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line, as seen on the bus |
| addr_sel_i | input | 1 | Address strap; supplies bit 1 of the address byte |
| sda_pull_o | output | 1 | Enable for the open-drain SDA pull-down (acknowledge) |
| mode_o | output | 4 | Output routing mode code |
| hp_atten_o | output | 2 | Headphone attenuation select |
| hp_r_off_o | output | 1 | Right headphone shutdown |
| in_mute_o | output | 1 | Input mute |
| vol_mono_o | output | 5 | Mono volume code |
| vol_left_o | output | 5 | Left volume code |
| vol_right_o | output | 5 | Right volume code |

## Verification
The bench keeps a behavioural model of the field bank and compares it against the outputs on every clock. It drives six kinds of transfer:
- Multi-byte transfers that write every prefix show that prefixes of different lengths are decoded separately. They also show that a prefix matching no field leaves every field untouched.
- Addresses that differ only in the strap bit or in the read flag show that the match uses exactly those bits.
- Bytes that follow a rejected address show that the block stays silent until the next start.
- Repeated starts, placed both after a matching address and after a rejected one, show that address reception restarts.
- A stop that cuts a byte short shows that an update needs a completed acknowledge.
- Pulses two clocks wide on each line show that a short pulse adds no bit and creates no start.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_DATA,
    ST_ACK_D,
    ST_SKIP
  } tgt_state_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned VOL_W  = 5;
  localparam int unsigned MODE_W = 4;
  localparam int unsigned ATT_W  = 2;
endpackage

// File: rtl/ctl_i2c_line_filt.sv
module ctl_i2c_line_filt #(
  parameter int unsigned LINES    = 2,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] filt_o
);
  localparam int unsigned CNT_W = $clog2(FILT_LEN + 1);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic             s1_q, s2_q, f_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q  <= 1'b1;
        s2_q  <= 1'b1;
        f_q   <= 1'b1;
        cnt_q <= '0;
      end else begin
        s1_q <= raw_i[g];
        s2_q <= s1_q;
        if (s2_q == f_q) begin
          cnt_q <= '0;
        end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
          // new level held for FILT_LEN clocks
          f_q   <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign filt_o[g] = f_q;
  end
endmodule

// File: rtl/ctl_i2c_engine.sv
module ctl_i2c_engine
  import ctl_i2c_pkg::*;
#(
  parameter logic [5:0] ADDR_BASE = 6'b111110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_pull_o,
  output logic              wr_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  tgt_state_e        state_q;
  logic              scl_q, sda_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [CNT_W-1:0]  bits_q;
  logic              scl_rise, scl_fall, start_det, stop_det, addr_hit, byte_full;

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  assign byte_full = (bits_q == CNT_W'(BYTE_W));
  // write flag must be 0; strap supplies the low address bit
  assign addr_hit  = (shreg_q[7:1] == {ADDR_BASE, addr_sel_i}) && !shreg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      shreg_q    <= '0;
      bits_q     <= '0;
      sda_pull_o <= 1'b0;
      wr_o       <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      wr_o  <= 1'b0;
      if (start_det) begin
        state_q    <= ST_ADDR;
        bits_q     <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        state_q    <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_DATA: begin
            if (scl_rise && !byte_full) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
              bits_q  <= bits_q + 1'b1;
            end else if (scl_fall && byte_full) begin
              if (state_q == ST_DATA) begin
                state_q    <= ST_ACK_D;
                sda_pull_o <= 1'b1;
              end else if (addr_hit) begin
                state_q    <= ST_ACK_A;
                sda_pull_o <= 1'b1;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          ST_ACK_A, ST_ACK_D: begin
            if (scl_fall) begin
              sda_pull_o <= 1'b0;
              bits_q     <= '0;
              state_q    <= ST_DATA;
              wr_o       <= (state_q == ST_ACK_D);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign byte_o = shreg_q;
endmodule

// File: rtl/ctl_i2c_regbank.sv
module ctl_i2c_regbank
  import ctl_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [ATT_W-1:0]  hp_atten_o,
  output logic              hp_r_off_o,
  output logic              in_mute_o,
  output logic [VOL_W-1:0]  vol_mono_o,
  output logic [VOL_W-1:0]  vol_left_o,
  output logic [VOL_W-1:0]  vol_right_o
);
  logic sel_mode, sel_hp, sel_mono, sel_left, sel_right;

  // prefix decode: 4-bit prefix for mode, 3-bit prefixes elsewhere
  assign sel_mode  = wr_i && (byte_i[7:4] == 4'b0011);
  assign sel_hp    = wr_i && (byte_i[7:5] == 3'b010);
  assign sel_mono  = wr_i && (byte_i[7:5] == 3'b100);
  assign sel_left  = wr_i && (byte_i[7:5] == 3'b110);
  assign sel_right = wr_i && (byte_i[7:5] == 3'b111);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o      <= '0;
      hp_atten_o  <= '0;
      hp_r_off_o  <= 1'b0;
      in_mute_o   <= 1'b0;
      vol_mono_o  <= '0;
      vol_left_o  <= '0;
      vol_right_o <= '0;
    end else begin
      if (sel_mode) mode_o <= byte_i[MODE_W-1:0];
      if (sel_hp) begin
        in_mute_o  <= byte_i[4];
        hp_r_off_o <= byte_i[2];
        hp_atten_o <= byte_i[ATT_W-1:0];
      end
      if (sel_mono)  vol_mono_o  <= byte_i[VOL_W-1:0];
      if (sel_left)  vol_left_o  <= byte_i[VOL_W-1:0];
      if (sel_right) vol_right_o <= byte_i[VOL_W-1:0];
    end
  end
endmodule

// File: rtl/ctl_i2c_regs.sv
module ctl_i2c_regs
  import ctl_i2c_pkg::*;
#(
  parameter int unsigned FILT_LEN  = 3,
  parameter logic [5:0]  ADDR_BASE = 6'b111110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_pull_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [ATT_W-1:0]  hp_atten_o,
  output logic              hp_r_off_o,
  output logic              in_mute_o,
  output logic [VOL_W-1:0]  vol_mono_o,
  output logic [VOL_W-1:0]  vol_left_o,
  output logic [VOL_W-1:0]  vol_right_o
);
  logic [1:0]        lines_f;
  logic              scl_f, sda_f, wr_en;
  logic [BYTE_W-1:0] wr_byte;

  ctl_i2c_line_filt #(.LINES(2), .FILT_LEN(FILT_LEN)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({scl_i, sda_i}),
    .filt_o (lines_f)
  );
  assign scl_f = lines_f[1];
  assign sda_f = lines_f[0];

  ctl_i2c_engine #(.ADDR_BASE(ADDR_BASE)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_f),
    .sda_i      (sda_f),
    .addr_sel_i (addr_sel_i),
    .sda_pull_o (sda_pull_o),
    .wr_o       (wr_en),
    .byte_o     (wr_byte)
  );

  ctl_i2c_regbank u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_en),
    .byte_i      (wr_byte),
    .mode_o      (mode_o),
    .hp_atten_o  (hp_atten_o),
    .hp_r_off_o  (hp_r_off_o),
    .in_mute_o   (in_mute_o),
    .vol_mono_o  (vol_mono_o),
    .vol_left_o  (vol_left_o),
    .vol_right_o (vol_right_o)
  );
endmodule

// File: rtl/ctl_i2c_regs_chk.sv
module ctl_i2c_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_f,
  input logic       sda_f,
  input logic       wr_en,
  input logic       sda_pull_o,
  input logic [3:0] mode_o,
  input logic [1:0] hp_atten_o,
  input logic       hp_r_off_o,
  input logic       in_mute_o,
  input logic [4:0] vol_mono_o,
  input logic [4:0] vol_left_o,
  input logic [4:0] vol_right_o
);
  logic [9:0] hp_grp;
  assign hp_grp = {5'b0, in_mute_o, hp_r_off_o, hp_atten_o, 1'b0};

  // R10
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_zero_chk: assert (mode_o == 0 && hp_grp == 0 && vol_mono_o == 0 &&
                              vol_left_o == 0 && vol_right_o == 0 && !sda_pull_o);
    end
  end

  // R12
  commit_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({mode_o, hp_grp, vol_mono_o, vol_left_o, vol_right_o}) |-> $past(wr_en));

  // R8
  one_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!$stable(mode_o), !$stable(hp_grp), !$stable(vol_mono_o),
                !$stable(vol_left_o), !$stable(vol_right_o)}) <= 1);

  // R1
  ack_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_f);

  // R3
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_f && $past(scl_f) && $rose(sda_f)) |=> !sda_pull_o);
endmodule

bind ctl_i2c_regs ctl_i2c_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_f       (scl_f),
  .sda_f       (sda_f),
  .wr_en       (wr_en),
  .sda_pull_o  (sda_pull_o),
  .mode_o      (mode_o),
  .hp_atten_o  (hp_atten_o),
  .hp_r_off_o  (hp_r_off_o),
  .in_mute_o   (in_mute_o),
  .vol_mono_o  (vol_mono_o),
  .vol_left_o  (vol_left_o),
  .vol_right_o (vol_right_o)
);

// File: tb/ctl_i2c_regs_tb_top.sv
module ctl_i2c_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 25;   // system clocks per SCL quarter period
  localparam int SETTLE     = 15;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1, addr_sel = 0;
  logic sda_pull;
  logic [3:0] mode;
  logic [1:0] hp_att;
  logic hp_off, mute;
  logic [4:0] v_mono, v_left, v_right;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_pull;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ctl_i2c_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(addr_sel), .sda_pull_o(sda_pull), .mode_o(mode),
    .hp_atten_o(hp_att), .hp_r_off_o(hp_off), .in_mute_o(mute),
    .vol_mono_o(v_mono), .vol_left_o(v_left), .vol_right_o(v_right)
  );

  int errors = 0, checks = 0, prints = 0;
  bit done = 0;
  longint t_change = 0;

  // behavioural model state
  int e_mode = 0, e_att = 0, e_off = 0, e_mute = 0, e_mono = 0, e_left = 0, e_right = 0;
  bit addressed = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model_byte(int b);
    int top3 = b / 32;
    if (b / 16 == 3) e_mode = b % 16;
    else if (top3 == 2) begin
      e_mute = (b / 16) % 2; e_off = (b / 4) % 2; e_att = b % 4;
    end
    else if (top3 == 4) e_mono = b % 32;
    else if (top3 == 6) e_left = b % 32;
    else if (top3 == 7) e_right = b % 32;
  endfunction

  // per-clock comparison against the model once the pipeline has settled
  always @(negedge clk) begin
    if (rst_n && !done && ($time - t_change) > SETTLE * CLK_PERIOD) begin
      checks++;
      if (mode != e_mode || hp_att != e_att || hp_off != e_off || mute != e_mute ||
          v_mono != e_mono || v_left != e_left || v_right != e_right) begin
        errors++;
        if (prints < 10) begin
          prints++;
          $display("FAIL R5/R6/R7 model: actual=%h_%h%h%h_%h_%h_%h expected=%h_%h%h%h_%h_%h_%h",
                   mode, mute, hp_off, hp_att, v_mono, v_left, v_right,
                   e_mode[3:0], e_mute[0], e_off[0], e_att[1:0], e_mono[4:0], e_left[4:0], e_right[4:0]);
        end
      end
    end
  end

  task automatic wclk(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1; wclk(Q); scl_m = 1; wclk(Q); sda_m = 0; wclk(Q); scl_m = 0; wclk(Q);
    t_change = $time;
  endtask

  task automatic i2c_stop();
    scl_m = 0; sda_m = 0; wclk(Q); scl_m = 1; wclk(Q); sda_m = 1; wclk(2 * Q);
    addressed = 0;
  endtask

  // glitch: 1 = short SCL pulse in a low phase, 2 = short SDA low pulse in bit 7 high phase
  task automatic send_byte(int b, int glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 0; wclk(Q / 2);
      if (glitch == 1 && i == 3) begin scl_m = 1; wclk(2); scl_m = 0; end
      sda_m = (b >> i) & 1; wclk(Q - Q / 2);
      scl_m = 1; wclk(Q / 2);
      if (glitch == 2 && i == 7) begin sda_m = 0; wclk(2); sda_m = 1; end
      wclk(Q - Q / 2);
    end
    scl_m = 0; wclk(Q / 2); sda_m = 1; wclk(Q - Q / 2);
    scl_m = 1; wclk(Q / 2);
    @(negedge clk); acked = sda_pull;
    wclk(Q - Q / 2);
    scl_m = 0;
    t_change = $time;
  endtask

  task automatic xfer(int addr, int bytes[$], bit exp_addr_ack, string req, int glitch = 0);
    bit a;
    i2c_start();
    send_byte(addr, 0, a);
    check(req, a, exp_addr_ack);
    addressed = exp_addr_ack;
    foreach (bytes[k]) begin
      send_byte(bytes[k], glitch, a);
      check(addressed ? "R9" : "R2", a, addressed);
      if (addressed) model_byte(bytes[k]);
    end
    i2c_stop();
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit a;
    wclk(3);
    @(negedge clk);
    // R10: outputs cleared in reset
    check("R10", {mode, hp_att, hp_off, mute, v_mono, v_left, v_right, sda_pull}, 0);
    wclk(2); rst_n = 1; t_change = $time; wclk(10);

    // R5, R6, R7, R9: every prefix in one transfer, pin low
    xfer(8'hF8, '{8'h3A, 8'h57, 8'h93, 8'hCC, 8'hF1}, 1, "R1");
    check("R5", mode, 4'hA);
    check("R6", {mute, hp_off, hp_att}, 4'b1111);
    check("R7", {v_mono, v_left, v_right}, {5'h13, 5'h0C, 5'h11});

    // R8: unmatched prefixes acked, no change
    xfer(8'hF8, '{8'h00, 8'h2F, 8'hBF, 8'h1E}, 1, "R1");
    check("R8", {mode, v_mono}, {4'hA, 5'h13});

    // R4: bit order distinguishes 0x31 from its reversal 0x8C
    xfer(8'hF8, '{8'h31, 8'h42}, 1, "R1");
    check("R4", mode, 1);
    check("R6", {mute, hp_off, hp_att}, 4'b0010);

    // R2: wrong strap bit and read flag are not acknowledged
    xfer(8'hFA, '{8'h3F, 8'h9F}, 0, "R2");
    check("R2", {mode, v_mono}, {4'h1, 5'h13});
    xfer(8'hF9, '{8'h3F}, 0, "R2");
    check("R2", mode, 1);

    // R1: strap high moves address to 0xFA
    addr_sel = 1; wclk(5);
    xfer(8'hF8, '{8'h3C}, 0, "R1");
    xfer(8'hFA, '{8'h3C, 8'hDE}, 1, "R1");
    check("R1", {mode, v_left}, {4'hC, 5'h1E});
    addr_sel = 0; wclk(5);

    // R3: repeated start after matched and after rejected address
    i2c_start();
    send_byte(8'hF8, 0, a); check("R3", a, 1); addressed = 1;
    send_byte(8'h85, 0, a); check("R3", a, 1); model_byte(8'h85);
    i2c_start();
    send_byte(8'hF9, 0, a); check("R3", a, 0); addressed = 0;
    send_byte(8'h3F, 0, a); check("R3", a, 0);
    i2c_start();
    send_byte(8'hF8, 0, a); check("R3", a, 1); addressed = 1;
    send_byte(8'hE7, 0, a); check("R3", a, 1); model_byte(8'hE7);
    i2c_stop();
    check("R3", {v_mono, v_right, mode}, {5'h05, 5'h07, 4'hC});

    // R12: stop after five bits of a mode byte leaves mode alone
    i2c_start();
    send_byte(8'hF8, 0, a); check("R12", a, 1);
    for (int i = 7; i >= 3; i--) begin
      scl_m = 0; wclk(Q / 2); sda_m = (8'h35 >> i) & 1; wclk(Q - Q / 2);
      scl_m = 1; wclk(Q);
    end
    i2c_stop();
    wclk(SETTLE + 5);
    check("R12", mode, 4'hC);

    // R11: short pulses on SCL and SDA are ignored
    xfer(8'hF8, '{8'h36, 8'h49}, 1, "R11", 1);
    check("R11", mode, 6);
    check("R11", {mute, hp_off, hp_att}, 4'b0001);
    xfer(8'hF8, '{8'h8A, 8'hC3}, 1, "R11", 2);
    check("R11", {v_mono, v_left}, {5'h0A, 5'h03});

    wclk(SETTLE + 5);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule